// File: doc/BRIEF.md
# IO Address Translation Unit

This unit turns a device virtual address into a physical address by reading one entry from a single-level page table in memory. Software programs a control word, which selects the size of the translation window, and a table base word. It does this through a word-indexed register file whose index space covers three 4 KiB pages of 32-bit words.

A device offers a virtual address on the request port. The unit clears the address bits that the window start has set, and turns the page number directly into a byte offset into the table. It then issues a single 32-bit read on its memory port and waits for the data. The entry arrives big-endian and is byte-swapped. Its page-number field is combined with the in-page offset, and the resulting physical address is presented with a one-cycle completion pulse.

Only the lowest `STORE_WORDS` register indices have storage. Indices above them read as zero and ignore writes. A request stays outstanding, with the busy flag set, until the memory returns data.

Top module: `io_xlate`

## Requirements
- R1: After reset every stored register reads 0, `xl_busy`, `xl_done` and `mem_req` are 0, and the window start is 0, so no address bit is cleared during translation.
- R2: A write with `reg_wr` high stores `reg_wdata` at `reg_idx` when `reg_idx < STORE_WORDS`, and `reg_rdata` shows the word at `reg_idx` combinationally. Indices at or above `STORE_WORDS` read 0 and ignore writes.
- R3: A write to index 0 (control) stores the full value and also sets the window start from bits [4:2]. Code 7 gives 0x80000000 and code k<7 gives 0xFE000000 shifted left by k. Bit 0 (enable) is only stored.
- R4: The entry address on `mem_addr` equals (index-1 word shifted left by 4, upper bits dropped) plus (((dva AND NOT window start) >> 10) AND NOT 3).
- R5: A request accepted while idle raises `xl_busy` and `mem_req` on the next cycle. Both stay high, with `mem_addr` stable, until a cycle in which `mem_rvalid` is high.
- R6: The returned word is byte-swapped (byte 0 becomes byte 3). The physical address is then ((swapped AND 0x07FFFF00) << 4) plus the low 12 bits of the masked dva.
- R7: `xl_done` is high for exactly the one cycle after the cycle in which `mem_rvalid` completes the fetch. `xl_pa` changes only then and holds its value otherwise.
- R8: `xl_req` while busy is ignored and does not alter the outstanding fetch or its result. `mem_rvalid` while idle is ignored and produces no done pulse or address change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_idx | input | IDX_W | Word index of the register access |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for `reg_idx` |
| xl_req | input | 1 | Translation request |
| xl_dva | input | 32 | Device virtual address |
| xl_busy | output | 1 | Translation outstanding |
| xl_done | output | 1 | One-cycle completion pulse |
| xl_pa | output | 32 | Translated physical address |
| mem_req | output | 1 | Table entry read request, held until data |
| mem_addr | output | 32 | Byte address of the table entry |
| mem_rvalid | input | 1 | Read data valid |
| mem_rdata | input | 32 | Read data, big-endian entry |

## Verification
A wrong window start or a wrong table base appears on `mem_addr` in the first cycle after a request is accepted, before any data returns. The bench therefore compares the entry address on every translation, with windows of several sizes and bases whose upper bits must be dropped. A broken byte swap or field extraction appears on `xl_pa` in the cycle of the done pulse. A handshake fault appears as a busy or request flag that drops early, an address that moves while a fetch waits through a long memory latency, or a done pulse triggered by stray read data.

// File: rtl/io_xlate.sv
module io_xlate #(
  parameter int STORE_WORDS = 16,
  parameter int WIN_PAGES   = 3,
  parameter logic [7:0][31:0] WIN_TABLE = {
    32'h8000_0000, 32'h8000_0000, 32'hc000_0000, 32'he000_0000,
    32'hf000_0000, 32'hf800_0000, 32'hfc00_0000, 32'hfe00_0000},
  localparam int WORDS = WIN_PAGES * 1024,
  localparam int IDX_W = $clog2(WORDS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             reg_wr,
  input  logic [IDX_W-1:0] reg_idx,
  input  logic [31:0]      reg_wdata,
  output logic [31:0]      reg_rdata,
  input  logic             xl_req,
  input  logic [31:0]      xl_dva,
  output logic             xl_busy,
  output logic             xl_done,
  output logic [31:0]      xl_pa,
  output logic             mem_req,
  output logic [31:0]      mem_addr,
  input  logic             mem_rvalid,
  input  logic [31:0]      mem_rdata
);
  localparam int SW_W = $clog2(STORE_WORDS);
  localparam logic [IDX_W-1:0] SW_LIM = IDX_W'(STORE_WORDS);

  logic [31:0] regs [STORE_WORDS];
  logic [31:0] win_start;
  logic [31:0] addr_q;
  logic [11:0] off_q;
  logic        busy_q;

  wire         hit    = reg_idx < SW_LIM;
  wire [31:0]  dva_m  = xl_dva & ~win_start;
  wire [31:0]  tbase  = {regs[1][27:0], 4'b0};
  wire [31:0]  eaddr  = tbase + ((dva_m >> 10) & ~32'd3);
  wire [31:0]  swp    = {mem_rdata[7:0], mem_rdata[15:8], mem_rdata[23:16], mem_rdata[31:24]};
  wire         accept = xl_req && !busy_q;
  wire         fill   = busy_q && mem_rvalid;

  assign reg_rdata = hit ? regs[reg_idx[SW_W-1:0]] : 32'd0;
  assign xl_busy   = busy_q;
  assign mem_req   = busy_q;
  assign mem_addr  = addr_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < STORE_WORDS; i++) regs[i] <= 32'd0;
      win_start <= 32'd0;
    end else if (reg_wr && hit) begin
      regs[reg_idx[SW_W-1:0]] <= reg_wdata;
      if (reg_idx == '0) win_start <= WIN_TABLE[reg_wdata[4:2]];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy_q  <= 1'b0;
      addr_q  <= 32'd0;
      off_q   <= 12'd0;
      xl_done <= 1'b0;
      xl_pa   <= 32'd0;
    end else begin
      xl_done <= 1'b0;
      if (accept) begin
        busy_q <= 1'b1;
        addr_q <= eaddr;
        off_q  <= dva_m[11:0];
      end
      if (fill) begin
        busy_q  <= 1'b0;
        xl_done <= 1'b1;
        xl_pa   <= {1'b0, swp[26:8], off_q};
      end
    end
  end
endmodule

// File: rtl/io_xlate_chk.sv
module io_xlate_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        xl_req,
  input logic        xl_busy,
  input logic        xl_done,
  input logic [31:0] xl_pa,
  input logic        mem_req,
  input logic [31:0] mem_addr,
  input logic        mem_rvalid
);
  // R5
  accept_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (xl_req && !xl_busy) |=> (xl_busy && mem_req));
  // R5
  hold_fetch_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_rvalid) |=> (mem_req && $stable(mem_addr)));
  // R7
  done_follows_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && mem_rvalid) |=> (xl_done && !xl_busy));
  // R7
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    xl_done |=> !xl_done);
  // R8
  pa_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(mem_req && mem_rvalid) |=> ($stable(xl_pa) && !xl_done));
endmodule

bind io_xlate io_xlate_chk u_chk (
  .clk(clk), .rst_n(rst_n), .xl_req(xl_req), .xl_busy(xl_busy),
  .xl_done(xl_done), .xl_pa(xl_pa), .mem_req(mem_req),
  .mem_addr(mem_addr), .mem_rvalid(mem_rvalid)
);

// File: tb/tb_io_xlate.sv
module tb_io_xlate;
  localparam int CLK_P = 10;
  localparam int IDX_W = 12;
  localparam int NV = 6;
  localparam logic [31:0] V_CTRL [NV] = '{32'h1d, 32'h01, 32'h15, 32'h19, 32'h0c, 32'h08};
  localparam logic [31:0] V_BASE [NV] = '{32'h0010_0000, 32'h0001_2340, 32'h0abc_def0,
                                          32'hf000_0010, 32'h0000_0100, 32'h0200_0000};
  localparam logic [31:0] V_DVA  [NV] = '{32'h8123_4567, 32'hfe7f_fabc, 32'hdead_beef,
                                          32'h7fff_ffff, 32'h0000_0fff, 32'hffff_f000};
  localparam int          V_LAT  [NV] = '{0, 3, 1, 5, 2, 7};

  logic clk = 0, rst_n = 0;
  logic reg_wr = 0, xl_req = 0, mem_rvalid = 0;
  logic [IDX_W-1:0] reg_idx = '0;
  logic [31:0] reg_wdata = 0, xl_dva = 0, mem_rdata = 0;
  logic [31:0] reg_rdata, xl_pa, mem_addr;
  logic xl_busy, xl_done, mem_req;
  int checks = 0, failures = 0;
  logic [31:0] cur_win = 0;

  io_xlate dut (.*);

  always #(CLK_P/2) clk = ~clk;

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] win_of(input logic [31:0] c);
    return (c[4:2] == 3'd7) ? 32'h8000_0000 : (32'hfe00_0000 << c[4:2]);
  endfunction
  function automatic logic [31:0] memf(input logic [31:0] a);
    return (a * 32'h0100_0193) ^ 32'ha5c3_0f96;
  endfunction
  function automatic logic [31:0] exp_ea(input logic [31:0] base, input logic [31:0] dva, input logic [31:0] w);
    return (base << 4) + (((dva & ~w) >> 10) & ~32'd3);
  endfunction
  function automatic logic [31:0] exp_pa(input logic [31:0] d, input logic [31:0] dva, input logic [31:0] w);
    logic [31:0] s;
    s = {d[7:0], d[15:8], d[23:16], d[31:24]};
    return ((s & 32'h07ff_ff00) << 4) + ((dva & ~w) & 32'hfff);
  endfunction

  task automatic wr(input int idx, input logic [31:0] v);
    reg_wr = 1; reg_idx = IDX_W'(idx); reg_wdata = v;
    @(negedge clk);
    reg_wr = 0;
  endtask

  task automatic xlate(input logic [31:0] base, input logic [31:0] dva, input int lat,
                       input bit poke, input string tag);
    logic [31:0] ea, d;
    bit held;
    ea = exp_ea(base, dva, cur_win);
    xl_req = 1; xl_dva = dva;
    @(negedge clk);
    xl_req = 0;
    chk(xl_busy && mem_req, "R5", {30'd0, xl_busy, mem_req}, 32'd3);
    chk(mem_addr == ea, tag, mem_addr, ea);
    held = 1;
    for (int k = 0; k < lat; k++) begin
      if (poke && k == 0) begin xl_req = 1; xl_dva = ~dva; end
      @(negedge clk);
      xl_req = 0;
      if (!(mem_req && xl_busy && mem_addr == ea && !xl_done)) held = 0;
    end
    chk(held, poke ? "R8" : "R5", mem_addr, ea);
    d = memf(ea);
    mem_rvalid = 1; mem_rdata = d;
    @(negedge clk);
    mem_rvalid = 0; mem_rdata = 32'hdead_0000;
    chk(xl_done && !xl_busy, "R7", {30'd0, xl_done, xl_busy}, 32'd2);
    chk(xl_pa == exp_pa(d, dva, cur_win), "R6", xl_pa, exp_pa(d, dva, cur_win));
    @(negedge clk);
    chk(!xl_done && !mem_req, "R7", {31'd0, xl_done}, 32'd0);
  endtask

  initial begin
    #(CLK_P * 200000);
    failures++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    logic [31:0] pa_keep;
    bit zero;
    repeat (3) @(negedge clk);
    rst_n = 1;
    zero = 1;
    for (int i = 0; i < 16; i++) begin
      reg_idx = IDX_W'(i); #1;
      if (reg_rdata != 0) zero = 0;
    end
    chk(zero, "R1 regs", reg_rdata, 0);
    chk(!xl_busy && !xl_done && !mem_req, "R1 flags", {29'd0, xl_busy, xl_done, mem_req}, 0);
    @(negedge clk);
    // R1: window start 0, high dva bits kept
    xlate(32'h0, 32'hc000_1234, 1, 0, "R1 window");

    // R2
    wr(5, 32'h1234_5678); reg_idx = 5; #1;
    chk(reg_rdata == 32'h1234_5678, "R2 store", reg_rdata, 32'h1234_5678);
    wr(16, 32'hffff_ffff); reg_idx = 16; #1;
    chk(reg_rdata == 0, "R2 upper", reg_rdata, 0);
    wr(3000, 32'h5555_aaaa); reg_idx = 3000; #1;
    chk(reg_rdata == 0, "R2 far", reg_rdata, 0);
    reg_idx = 0; #1;
    chk(reg_rdata == 0, "R2 alias", reg_rdata, 0);

    for (int v = 0; v < NV; v++) begin
      wr(0, V_CTRL[v]); cur_win = win_of(V_CTRL[v]);
      reg_idx = 0; #1;
      chk(reg_rdata == V_CTRL[v], "R3 stored", reg_rdata, V_CTRL[v]);
      @(negedge clk);
      wr(1, V_BASE[v]);
      xlate(V_BASE[v], V_DVA[v], V_LAT[v], 0, "R4");
    end

    // R3: code 7 with extra bits stored as written
    wr(0, 32'hf000_001c); cur_win = 32'h8000_0000; wr(1, 32'h0000_4000);
    reg_idx = 0; #1;
    chk(reg_rdata == 32'hf000_001c, "R3 full", reg_rdata, 32'hf000_001c);
    @(negedge clk);
    xlate(32'h0000_4000, 32'hffff_ffff, 2, 0, "R3 code7");

    // R8: request while busy ignored
    xlate(32'h0000_4000, 32'h8765_4321, 4, 1, "R4");
    // R8: stray read data while idle
    pa_keep = xl_pa;
    mem_rvalid = 1; mem_rdata = 32'h1111_2222;
    @(negedge clk);
    mem_rvalid = 0;
    @(negedge clk);
    chk(!xl_done && xl_pa == pa_keep && !xl_busy, "R8 idle", xl_pa, pa_keep);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule